// File: doc/BRIEF.md
# Threshold-Limited Wide Adder/Subtractor

This block adds or subtracts two operands of independent widths and signedness, and never builds any single arithmetic operator wider than a set threshold. The wider of the two operand widths is the working width. When the working width is above the threshold, both operands are extended to it and each is cut in two. The lower half is floor(width/2) bits and the upper half takes the rest, so an odd width gives the extra bit to the upper half.

The two lower halves are combined as unsigned values into a result one bit wider than the half. Its top bit is the carry (add) or the borrow (subtract). The two upper halves are combined with the operands' own signedness. A third operator of the same kind folds the lower carry or borrow into the upper result, and is signed if either operand is signed. Any of these three pieces that is still above the threshold is split again by the same rule during elaboration. The output is the merged upper result placed above the lower bits, cut to the requested output width.

The operation (add or subtract) is fixed by a parameter, and every piece uses the same one. Legal settings are a threshold of at least 3 and an output width no larger than the working width plus one. The block has no clock.

Top module: `wide_addsub`

## Requirements
- R1: With MODE set to add, y equals (ext(a) + ext(b)) mod 2^Y_W, where ext widens an operand to Y_W bits.
- R2: With MODE set to subtract, y equals (ext(a) - ext(b)) mod 2^Y_W. An operand subtracted from itself gives y = 0.
- R3: ext sign-extends an operand (copies its most significant bit) when that operand's signed flag is 1, and zero-extends it when the flag is 0. The flags of a and b act independently. With b zero, y equals ext(a).
- R4: For an odd working width above the threshold, the upper slice holds the extra bit and the result still meets R1/R2.
- R5: A carry or borrow produced in any lower slice reaches every higher bit. For example, an all-ones operand plus one gives zero in every bit below the working width.
- R6: The most negative signed value, zero and all-ones operands give results that meet R1/R2.
- R7: When Y_W is smaller than the working width plus one, y holds the low Y_W bits of the full result.
- R8: When the working width is at or below MAX_W, a single operator computes y, with the same result as R1/R2.
- R9: y[0] equals the XOR of bit 0 of the two operands in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | A_W | First operand (minuend when subtracting) |
| b | input | B_W | Second operand (subtrahend when subtracting) |
| y | output | Y_W | Sum or difference, cut to Y_W bits |

## Verification
The checker assumes its parameters are legal: a threshold of 3 or more, and an output no wider than the working width plus one. For any other setting the extension of a mixed-sign result above that width is not defined. It also assumes both operands are fully known, and it skips its checks while either one holds unknown bits. The bench instantiates the block only in legal settings: odd and even working widths, mixed signedness, a narrowed output and an unsplit case. It drives every operand bit with either a random value or a directed corner, so no input is ever left floating.

// File: rtl/wide_addsub_pkg.sv
package wide_addsub_pkg;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } op_mode_e;

    function automatic int wmax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/wide_addsub_leaf.sv
module wide_addsub_leaf
    import wide_addsub_pkg::*;
#(
    parameter int       AW   = 8,
    parameter int       BW   = 8,
    parameter bit       ASG  = 1'b0,
    parameter bit       BSG  = 1'b0,
    parameter int       YW   = 9,
    parameter op_mode_e MODE = MODE_ADD
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [YW-1:0] y
);

    logic [YW-1:0] ax;
    logic [YW-1:0] bx;

    // widen or cut each operand to the result width
    if (AW >= YW) begin : g_a_cut
        assign ax = a[YW-1:0];
    end else begin : g_a_ext
        assign ax = {{(YW-AW){ASG ? a[AW-1] : 1'b0}}, a};
    end

    if (BW >= YW) begin : g_b_cut
        assign bx = b[YW-1:0];
    end else begin : g_b_ext
        assign bx = {{(YW-BW){BSG ? b[BW-1] : 1'b0}}, b};
    end

    if (MODE == MODE_SUB) begin : g_sub
        assign y = ax - bx;
    end else begin : g_add
        assign y = ax + bx;
    end

endmodule

// File: rtl/wide_addsub_node.sv
module wide_addsub_node
    import wide_addsub_pkg::*;
#(
    parameter int       AW   = 8,
    parameter int       BW   = 8,
    parameter bit       ASG  = 1'b0,
    parameter bit       BSG  = 1'b0,
    parameter int       YW   = 9,
    parameter int       MAXW = 128,
    parameter op_mode_e MODE = MODE_ADD
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [YW-1:0] y
);

    localparam int W   = wmax(AW, BW);
    localparam int LO  = W / 2;
    localparam int HI  = W - LO;
    localparam bit ANY = ASG | BSG;

    if (W <= MAXW) begin : g_leaf
        wide_addsub_leaf #(
            .AW(AW), .BW(BW), .ASG(ASG), .BSG(BSG), .YW(YW), .MODE(MODE)
        ) u_leaf (
            .a(a), .b(b), .y(y)
        );
    end else begin : g_split
        logic [W-1:0]  aw_x;
        logic [W-1:0]  bw_x;
        logic [LO:0]   y_lo;
        logic [HI:0]   y_hi;
        logic [HI:0]   y_mg;
        logic [W:0]    full;

        if (AW == W) begin : g_a_same
            assign aw_x = a;
        end else begin : g_a_pad
            assign aw_x = {{(W-AW){ASG ? a[AW-1] : 1'b0}}, a};
        end

        if (BW == W) begin : g_b_same
            assign bw_x = b;
        end else begin : g_b_pad
            assign bw_x = {{(W-BW){BSG ? b[BW-1] : 1'b0}}, b};
        end

        // lower slices: always unsigned, top bit is carry/borrow
        wide_addsub_node #(
            .AW(LO), .BW(LO), .ASG(1'b0), .BSG(1'b0),
            .YW(LO+1), .MAXW(MAXW), .MODE(MODE)
        ) u_lo (
            .a(aw_x[LO-1:0]), .b(bw_x[LO-1:0]), .y(y_lo)
        );

        // upper slices keep the operands' own signedness
        wide_addsub_node #(
            .AW(HI), .BW(HI), .ASG(ASG), .BSG(BSG),
            .YW(HI+1), .MAXW(MAXW), .MODE(MODE)
        ) u_hi (
            .a(aw_x[W-1:LO]), .b(bw_x[W-1:LO]), .y(y_hi)
        );

        // fold the lower carry/borrow into the upper result
        wide_addsub_node #(
            .AW(HI+1), .BW(2), .ASG(ANY), .BSG(ANY),
            .YW(HI+1), .MAXW(MAXW), .MODE(MODE)
        ) u_mg (
            .a(y_hi), .b({1'b0, y_lo[LO]}), .y(y_mg)
        );

        assign full = {y_mg, y_lo[LO-1:0]};
        assign y    = full[YW-1:0];
    end

endmodule

// File: rtl/wide_addsub.sv
module wide_addsub
    import wide_addsub_pkg::*;
#(
    parameter int       A_W   = 160,
    parameter int       B_W   = 140,
    parameter bit       A_SGN = 1'b0,
    parameter bit       B_SGN = 1'b0,
    parameter int       Y_W   = 161,
    parameter int       MAX_W = 128,
    parameter op_mode_e MODE  = MODE_ADD
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [Y_W-1:0] y
);

    localparam int WORK_W = wmax(A_W, B_W);

    if (MAX_W < 3) begin : g_bad_thresh
        $error("wide_addsub: MAX_W must be at least 3");
    end
    if (Y_W > WORK_W + 1) begin : g_bad_width
        $error("wide_addsub: Y_W must not exceed working width plus one");
    end

    wide_addsub_node #(
        .AW(A_W), .BW(B_W), .ASG(A_SGN), .BSG(B_SGN),
        .YW(Y_W), .MAXW(MAX_W), .MODE(MODE)
    ) u_root (
        .a(a), .b(b), .y(y)
    );

endmodule

// File: rtl/wide_addsub_chk.sv
module wide_addsub_chk
    import wide_addsub_pkg::*;
#(
    parameter int       A_W   = 160,
    parameter int       B_W   = 140,
    parameter bit       A_SGN = 1'b0,
    parameter bit       B_SGN = 1'b0,
    parameter int       Y_W   = 161,
    parameter op_mode_e MODE  = MODE_ADD
) (
    input logic [A_W-1:0] a,
    input logic [B_W-1:0] b,
    input logic [Y_W-1:0] y
);

    logic [Y_W-1:0] ea;
    logic [Y_W-1:0] eb;
    logic [Y_W-1:0] want;

    if (A_W >= Y_W) begin : g_ea_cut
        assign ea = a[Y_W-1:0];
    end else begin : g_ea_ext
        assign ea = {{(Y_W-A_W){A_SGN ? a[A_W-1] : 1'b0}}, a};
    end
    if (B_W >= Y_W) begin : g_eb_cut
        assign eb = b[Y_W-1:0];
    end else begin : g_eb_ext
        assign eb = {{(Y_W-B_W){B_SGN ? b[B_W-1] : 1'b0}}, b};
    end

    // a single unsplit operator as the model
    assign want = (MODE == MODE_SUB) ? (ea - eb) : (ea + eb);

    always_comb begin
        if (!$isunknown({a, b})) begin
            // R1
            result_match_chk: assert (y == want)
                else $error("result mismatch y=%h want=%h", y, want);
            // R9
            lsb_parity_chk: assert (y[0] == (a[0] ^ b[0]))
                else $error("bit 0 parity wrong");
            // R3
            if (eb == '0) begin
                zero_rhs_chk: assert (y == ea)
                    else $error("zero rhs does not pass a through");
            end
            // R2
            if (MODE == MODE_SUB && ea == eb) begin
                self_diff_chk: assert (y == '0)
                    else $error("equal operands do not give zero");
            end
        end
    end

endmodule

bind wide_addsub wide_addsub_chk #(
    .A_W(A_W), .B_W(B_W), .A_SGN(A_SGN), .B_SGN(B_SGN), .Y_W(Y_W), .MODE(MODE)
) u_chk (
    .a(a), .b(b), .y(y)
);

// File: tb/test_wide_addsub.sv
module test_wide_addsub;
    import wide_addsub_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // inst0: mixed sign add, odd width 37, deep split
    logic [36:0] a0; logic [28:0] b0; logic [37:0] y0;
    // inst1: signed subtract, odd width 33
    logic [32:0] a1; logic [32:0] b1; logic [33:0] y1;
    // inst2: unsigned add, narrowed output
    logic [63:0] a2; logic [63:0] b2; logic [39:0] y2;
    // inst3: no split, mixed sign subtract
    logic [19:0] a3; logic [11:0] b3; logic [20:0] y3;

    wide_addsub #(.A_W(37), .B_W(29), .A_SGN(1'b1), .B_SGN(1'b0),
                  .Y_W(38), .MAX_W(4), .MODE(MODE_ADD))
        i_wide_addsub (.a(a0), .b(b0), .y(y0));
    wide_addsub #(.A_W(33), .B_W(33), .A_SGN(1'b1), .B_SGN(1'b1),
                  .Y_W(34), .MAX_W(5), .MODE(MODE_SUB))
        i_wide_addsub_s (.a(a1), .b(b1), .y(y1));
    wide_addsub #(.A_W(64), .B_W(64), .A_SGN(1'b0), .B_SGN(1'b0),
                  .Y_W(40), .MAX_W(8), .MODE(MODE_ADD))
        i_wide_addsub_t (.a(a2), .b(b2), .y(y2));
    wide_addsub #(.A_W(20), .B_W(12), .A_SGN(1'b0), .B_SGN(1'b1),
                  .Y_W(21), .MAX_W(128), .MODE(MODE_SUB))
        i_wide_addsub_u (.a(a3), .b(b3), .y(y3));

    function automatic logic [127:0] msk(input int w);
        return (w >= 128) ? '1 : ((128'd1 << w) - 128'd1);
    endfunction

    function automatic logic [127:0] ref_op(input logic [127:0] a, input logic [127:0] b,
                                            input int aw, input int bw, input bit sa,
                                            input bit sb, input bit sub, input int yw);
        logic [127:0] xa, xb, r;
        xa = a & msk(aw);
        xb = b & msk(bw);
        if (sa && a[aw-1]) xa = xa | ~msk(aw);
        if (sb && b[bw-1]) xb = xb | ~msk(bw);
        r = sub ? (xa - xb) : (xa + xb);
        return r & msk(yw);
    endfunction

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_vec(input logic [127:0] ra, input logic [127:0] rb, input string tag);
        @(posedge clk);
        a0 = ra[36:0]; b0 = rb[28:0];
        a1 = ra[32:0]; b1 = rb[32:0];
        a2 = ra[63:0]; b2 = rb[63:0];
        a3 = ra[19:0]; b3 = rb[11:0];
        @(negedge clk);
        chk({tag, " R1 R3 R4 inst0"}, 128'(y0), ref_op(ra, rb, 37, 29, 1, 0, 0, 38));
        chk({tag, " R2 R3 R4 inst1"}, 128'(y1), ref_op(ra, rb, 33, 33, 1, 1, 1, 34));
        chk({tag, " R7 inst2"},       128'(y2), ref_op(ra, rb, 64, 64, 0, 0, 0, 40));
        chk({tag, " R8 inst3"},       128'(y3), ref_op(ra, rb, 20, 12, 0, 1, 1, 21));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0; a3 = '0; b3 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // zero inputs give zero (R6)
        run_vec('0, '0, "R6 zero");
        // all ones both (R6)
        run_vec('1, '1, "R6 ones");
        // carry/borrow ripple: all ones plus one, zero minus one (R5)
        run_vec('1, 128'd1, "R5 ripple");
        run_vec('0, 128'd1, "R5 borrow");
        // most negative signed values (R6)
        run_vec(128'd1 << 36, 128'd1 << 28, "R6 minneg0");
        run_vec(128'd1 << 32, 128'd1, "R6 minneg1");
        run_vec(128'd1 << 32, 128'd1 << 32, "R2 self");
        // b zero passes a through (R3)
        run_vec(128'h1_2345_6789_ABCD_EF01, '0, "R3 bzero");
        // carry exactly at a slice boundary (R4)
        run_vec(128'h0000_0000_FFFF_FFFF, 128'h0000_0000_0000_0001, "R4 boundary");
        run_vec(128'h0000_0000_7FFF_FFFF, 128'h0000_0000_FFFF_FFFF, "R5 mix");

        for (int i = 0; i < 400; i++) begin
            logic [127:0] ra, rb;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            case ($urandom % 8)
                0: ra = '1;
                1: rb = '1;
                2: rb = '0;
                3: rb = ra;
                default: ;
            endcase
            run_vec(ra, rb, "rand R9");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule